// File: doc/BRIEF.md
# Serial EEPROM Command Guard

This block is the instruction front end of a three-wire serial EEPROM slave. It watches chip select, serial clock and serial data in, finds the start bit, and shifts in the two op-code bits, the address (MSB first) and, where present, the data word. From the start bit until chip select drops, it counts every serial clock edge.

When chip select falls, an instruction that changes the array (write, erase, erase-all, write-all) is passed to the array port only if the count is exactly the value that instruction needs for the configured organization. On any mismatch the instruction is dropped and an abort pulse is raised. A clock glitch that shifts the frame by one bit therefore cannot write wrong data at a wrong address. Read and the other non-modifying instructions pass through the front end without a count check and produce no request.

The serial inputs are sampled on the system clock, so they must already be synchronous to it. The organization is chosen by a parameter: a byte-wide array with `ADDR_W_X8` address bits, or a 16-bit-wide array with one address bit fewer.

Top module: `eeprom_cmd_guard`

## Requirements
- R1: After reset, `reqValid` and `abortPulse` are both 0.
- R2: Data-in zeros clocked while chip select is high and before the first 1 are ignored. The first 1 is the start bit and counts as clock 1.
- R3: WRITE (op-code bits 0 then 1) commits with `reqKind`=0 and the shifted address and data only when exactly 3+A+D clocks were counted (A = address width, D = data width).
- R4: ERASE (op-code 11) commits with `reqKind`=1 and the address only when exactly 3+A clocks were counted.
- R5: Erase-all (op-code 00, top two address bits 10) commits with `reqKind`=2 only when exactly 3+A clocks were counted.
- R6: Write-all (op-code 00, top two address bits 01) commits with `reqKind`=3 and the data only when exactly 3+A+D clocks were counted.
- R7: For a modifying instruction, any count other than the expected one (one extra glitch clock, or too few) gives no commit and a one-cycle `abortPulse`.
- R8: The clock counter saturates at its maximum instead of wrapping, so a long burst of extra clocks never matches an expected count.
- R9: `reqValid` and `abortPulse` are single-cycle pulses, asserted in the system-clock cycle after the one in which chip select is seen low after being high.
- R10: READ (op-code 10) and op-code 00 with top address bits 11 or 00 give neither a commit nor an abort, whatever the count.
- R11: With `ORG_X16`=1 the address is one bit narrower and the data field is 16 bits, and the expected counts follow from those widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select, active high |
| sclkIn | input | 1 | Serial clock; data is taken on its rising edge |
| sdIn | input | 1 | Serial data in |
| reqValid | output | 1 | One-cycle commit request to the array |
| reqKind | output | 2 | 0 write, 1 erase, 2 erase-all, 3 write-all |
| reqAddr | output | A | Address of the committed request |
| reqData | output | D | Data of the committed request |
| abortPulse | output | 1 | One-cycle flag: a modifying instruction was discarded |

## Verification
The assertions assume that chip select, serial clock and serial data change only between system-clock edges, and that each serial clock level lasts at least one system-clock cycle, so every rising edge is seen exactly once. The stimulus changes all serial inputs on the falling system-clock edge and holds each serial clock phase for a full cycle. Chip select is raised before the first serial clock and dropped only while the serial clock is low.

// File: rtl/eeguard_pkg.sv
package eeguard_pkg;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_ERASE = 2'd1,
    KIND_ERAL  = 2'd2,
    KIND_WRAL  = 2'd3
  } reqKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // new frame begins
    logic shiftEn;   // take one serial bit
    logic headLoad;  // snapshot op-code and address
    logic latchOut;  // load request address/data outputs
  } dpStrobe_t;

endpackage

// File: rtl/eeguard_dp.sv
module eeguard_dp
  import eeguard_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdIn,
  output logic [1:0]        opCode,
  output logic [1:0]        addrTop,
  output logic              headValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);
  localparam int HEAD_W  = 2 + ADDR_W;
  localparam int FRAME_W = HEAD_W + DATA_W;

  logic [FRAME_W-1:0] shiftReg, nextShift;
  logic [HEAD_W-1:0]  headReg;

  assign nextShift = {shiftReg[FRAME_W-2:0], sdIn};
  assign opCode    = headReg[HEAD_W-1 -: 2];
  assign addrTop   = headReg[ADDR_W-1 -: 2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      headReg   <= '0;
      headValid <= 1'b0;
      outAddr   <= '0;
      outData   <= '0;
    end else begin
      if (strobe.clear) begin
        shiftReg  <= '0;
        headValid <= 1'b0;
      end else if (strobe.shiftEn) begin
        shiftReg <= nextShift;
        if (strobe.headLoad) begin
          headReg   <= nextShift[HEAD_W-1:0];
          headValid <= 1'b1;
        end
      end
      if (strobe.latchOut) begin
        outAddr <= headReg[ADDR_W-1:0];
        outData <= shiftReg[DATA_W-1:0];
      end
    end
  end

  // R3: op-code and address are held once the header has been taken
  a_r3_head_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && strobe.headLoad && !strobe.clear) |=> headValid);

  // R2: a fresh frame forgets any earlier header
  a_r2_clear_head: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !headValid);

endmodule

// File: rtl/eeguard_ctrl.sv
module eeguard_ctrl
  import eeguard_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csIn,
  input  logic       sclkIn,
  input  logic       sdIn,
  input  logic [1:0] opCode,
  input  logic [1:0] addrTop,
  input  logic       headValid,
  output dpStrobe_t  strobe,
  output logic       commitPulse,
  output logic       abortPulse,
  output reqKind_e   commitKind
);
  localparam int HEAD_CNT_I = 3 + ADDR_W;
  localparam int FULL_CNT_I = HEAD_CNT_I + DATA_W;
  localparam int CNT_W      = $clog2(FULL_CNT_I + 1) + 1;
  localparam logic [CNT_W-1:0] HEAD_CNT = CNT_W'(HEAD_CNT_I);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FULL_CNT_I);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic             csPrev, sclkPrev, active;
  logic [CNT_W-1:0] cnt;
  logic             sclkRise, csFall, startEdge, isModify, evaluate;
  logic [CNT_W-1:0] expCnt;
  reqKind_e         kind;

  assign sclkRise  = sclkIn && !sclkPrev;
  assign csFall    = csPrev && !csIn;
  assign startEdge = !active && csIn && sclkRise && sdIn;

  always_comb begin
    strobe          = '0;
    strobe.clear    = startEdge;
    strobe.shiftEn  = active && csIn && sclkRise;
    strobe.headLoad = strobe.shiftEn && (cnt == HEAD_CNT - 1'b1);
    strobe.latchOut = evaluate;
  end

  // instruction decode for the count check
  always_comb begin
    isModify = 1'b0;
    expCnt   = FULL_CNT;
    kind     = KIND_WRITE;
    unique case (opCode)
      2'b01: begin isModify = 1'b1; kind = KIND_WRITE; expCnt = FULL_CNT; end
      2'b11: begin isModify = 1'b1; kind = KIND_ERASE; expCnt = HEAD_CNT; end
      2'b00: begin
        if (addrTop == 2'b10) begin
          isModify = 1'b1; kind = KIND_ERAL; expCnt = HEAD_CNT;
        end else if (addrTop == 2'b01) begin
          isModify = 1'b1; kind = KIND_WRAL; expCnt = FULL_CNT;
        end
      end
      default: isModify = 1'b0;
    endcase
  end

  assign evaluate = csFall && active && headValid && isModify;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev      <= 1'b0;
      sclkPrev    <= 1'b0;
      active      <= 1'b0;
      cnt         <= '0;
      commitPulse <= 1'b0;
      abortPulse  <= 1'b0;
      commitKind  <= KIND_WRITE;
    end else begin
      csPrev      <= csIn;
      sclkPrev    <= sclkIn;
      commitPulse <= evaluate && (cnt == expCnt);
      abortPulse  <= evaluate && (cnt != expCnt);
      if (evaluate) commitKind <= kind;
      if (csFall) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (startEdge) begin
        active <= 1'b1;
        cnt    <= CNT_W'(1);
      end else if (strobe.shiftEn && cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: commit lasts one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse);

  // R9: commit follows chip select going low
  a_r9_after_cs_fall: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> (!$past(csIn) && $past(csIn, 2)));

  // R7: a frame is either committed or aborted, never both
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(commitPulse && abortPulse));

  // R8: within a frame the count never goes back
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active)) |-> (cnt >= $past(cnt)));

  // R2: a frame only opens on a 1 on data in
  a_r2_start_is_one: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(sdIn));

endmodule

// File: rtl/eeprom_cmd_guard.sv
module eeprom_cmd_guard
  import eeguard_pkg::*;
#(
  parameter bit ORG_X16   = 1'b0,
  parameter int ADDR_W_X8 = 9,
  localparam int ADDR_W   = ORG_X16 ? ADDR_W_X8 - 1 : ADDR_W_X8,
  localparam int DATA_W   = ORG_X16 ? 16 : 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              sclkIn,
  input  logic              sdIn,
  output logic              reqValid,
  output logic [1:0]        reqKind,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              abortPulse
);
  dpStrobe_t  strobe;
  logic [1:0] opCode, addrTop;
  logic       headValid;
  reqKind_e   commitKind;

  eeguard_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .sdIn(sdIn),
    .opCode(opCode), .addrTop(addrTop), .headValid(headValid),
    .strobe(strobe), .commitPulse(reqValid), .abortPulse(abortPulse),
    .commitKind(commitKind)
  );

  eeguard_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdIn(sdIn),
    .opCode(opCode), .addrTop(addrTop), .headValid(headValid),
    .outAddr(reqAddr), .outData(reqData)
  );

  assign reqKind = commitKind;

endmodule

// File: tb/sim_eeprom_cmd_guard.sv
module sim_eeprom_cmd_guard;

  logic clk = 1'b0, rstN = 1'b0;
  logic cs0 = 1'b0, cs1 = 1'b0, sclk = 1'b0, sd = 1'b0;
  logic       v0, ab0, v1, ab1;
  logic [1:0] k0, k1;
  logic [8:0] a0;
  logic [7:0] d0, a1;
  logic [15:0] d1;
  int nChecks = 0, nFail = 0;

  always #10 clk = ~clk;  // 50 MHz

  eeprom_cmd_guard #(.ORG_X16(1'b0), .ADDR_W_X8(9)) u0 (
    .clk(clk), .rstN(rstN), .csIn(cs0), .sclkIn(sclk), .sdIn(sd),
    .reqValid(v0), .reqKind(k0), .reqAddr(a0), .reqData(d0), .abortPulse(ab0));

  eeprom_cmd_guard #(.ORG_X16(1'b1), .ADDR_W_X8(9)) u1 (
    .clk(clk), .rstN(rstN), .csIn(cs1), .sclkIn(sclk), .sdIn(sd),
    .reqValid(v1), .reqKind(k1), .reqAddr(a1), .reqData(d1), .abortPulse(ab1));

  typedef struct packed {
    logic [7:0]  n;      // serial bits after the start bit
    logic [31:0] pat;    // sent MSB first from bit n-1
    logic        expV;
    logic        expA;
    logic [1:0]  kind;
    logic [8:0]  addr;
    logic [7:0]  data;
    logic        chkData;
    logic [23:0] tag;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t TABLE [NVEC] = '{
    '{8'd19, 32'({2'b01, 9'h1A5, 8'h3C}),       1'b1, 1'b0, 2'd0, 9'h1A5, 8'h3C, 1'b1, "R3 "},
    '{8'd11, 32'({2'b11, 9'h0F0}),              1'b1, 1'b0, 2'd1, 9'h0F0, 8'h00, 1'b0, "R4 "},
    '{8'd11, 32'({2'b00, 9'h100}),              1'b1, 1'b0, 2'd2, 9'h100, 8'h00, 1'b0, "R5 "},
    '{8'd19, 32'({2'b00, 9'h080, 8'hA5}),       1'b1, 1'b0, 2'd3, 9'h080, 8'hA5, 1'b1, "R6 "},
    '{8'd20, 32'({2'b01, 1'b1, 9'h1A5, 8'h3C}), 1'b0, 1'b1, 2'd0, 9'h000, 8'h00, 1'b0, "R7 "},
    '{8'd18, 32'({2'b01, 9'h1A5, 7'h1E}),       1'b0, 1'b1, 2'd0, 9'h000, 8'h00, 1'b0, "R7 "},
    '{8'd12, 32'({2'b11, 9'h0F0, 1'b1}),        1'b0, 1'b1, 2'd0, 9'h000, 8'h00, 1'b0, "R7 "},
    '{8'd11, 32'({2'b10, 9'h033}),              1'b0, 1'b0, 2'd0, 9'h000, 8'h00, 1'b0, "R10"},
    '{8'd25, 32'({2'b10, 9'h033, 14'h0}),       1'b0, 1'b0, 2'd0, 9'h000, 8'h00, 1'b0, "R10"},
    '{8'd11, 32'({2'b00, 9'h180}),              1'b0, 1'b0, 2'd0, 9'h000, 8'h00, 1'b0, "R10"},
    '{8'd18, 32'({2'b00, 9'h080, 7'h05}),       1'b0, 1'b1, 2'd0, 9'h000, 8'h00, 1'b0, "R6 "},
    '{8'd19, 32'({2'b00, 9'h100, 8'hFF}),       1'b0, 1'b1, 2'd0, 9'h000, 8'h00, 1'b0, "R5 "}
  };

  task automatic chk(input bit ok, input logic [23:0] tag,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bitClk(input logic b);
    @(negedge clk); sd = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
  endtask

  // leaves the caller at the negedge right after the result register loads
  task automatic sendFrame(input bit sel, input int lead, input int n,
                           input logic [127:0] pat);
    @(negedge clk);
    if (sel) cs1 = 1'b1; else cs0 = 1'b1;
    sclk = 1'b0;
    for (int i = 0; i < lead; i++) bitClk(1'b0);
    bitClk(1'b1);
    for (int i = n - 1; i >= 0; i--) bitClk(pat[i]);
    cs0 = 1'b0; cs1 = 1'b0; sd = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(v0 == 1'b0 && ab0 == 1'b0, "R1 ", {v0, ab0}, 0);
    chk(v1 == 1'b0 && ab1 == 1'b0, "R1 ", {v1, ab1}, 0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = TABLE[i];
      sendFrame(1'b0, 0, int'(v.n), 128'(v.pat));
      chk(v0 == v.expV, v.tag, v0, v.expV);
      chk(ab0 == v.expA, v.tag, ab0, v.expA);
      if (v.expV) begin
        chk(k0 == v.kind, v.tag, k0, v.kind);
        chk(a0 == v.addr, v.tag, a0, v.addr);
        if (v.chkData) chk(d0 == v.data, v.tag, d0, v.data);
      end
      @(negedge clk);
      chk(v0 == 1'b0 && ab0 == 1'b0, "R9 ", {v0, ab0}, 0);  // single-cycle pulse
    end

    // R2: leading zeros before the start bit are not counted
    sendFrame(1'b0, 5, 19, 128'({2'b01, 9'h0C3, 8'h99}));
    chk(v0 == 1'b1, "R2 ", v0, 1);
    chk(a0 == 9'h0C3 && d0 == 8'h99, "R2 ", {a0, d0}, {9'h0C3, 8'h99});

    // R8: 84 clocks would alias to 20 on a wrapping 6-bit counter
    sendFrame(1'b0, 0, 83, 128'({2'b01, 9'h1A5}) << 72);
    chk(v0 == 1'b0, "R8 ", v0, 0);
    chk(ab0 == 1'b1, "R8 ", ab0, 1);

    // R11: 16-bit organization, 8 address bits
    sendFrame(1'b1, 0, 26, 128'({2'b01, 8'h5A, 16'hBEEF}));
    chk(v1 == 1'b1 && k1 == 2'd0, "R11", {v1, k1}, {1'b1, 2'd0});
    chk(a1 == 8'h5A && d1 == 16'hBEEF, "R11", {a1, d1}, {8'h5A, 16'hBEEF});
    chk(v0 == 1'b0 && ab0 == 1'b0, "R11", {v0, ab0}, 0);
    sendFrame(1'b1, 0, 10, 128'({2'b11, 8'h3C}));
    chk(v1 == 1'b1 && k1 == 2'd1 && a1 == 8'h3C, "R11", {v1, k1, a1}, {1'b1, 2'd1, 8'h3C});
    sendFrame(1'b1, 0, 19, 128'({2'b01, 9'h1A5, 8'h3C}));
    chk(v1 == 1'b0 && ab1 == 1'b1, "R11", {v1, ab1}, 2'b01);

    finishRun();
  end

endmodule